// File: doc/BRIEF.md
# Byte-wide serial master with flag handshake

This block is an 8-bit serial peripheral master behind a three-register bus: a control register, a control/status register and a data register. Writing a byte into the data register launches a full-duplex exchange. The byte leaves on `mosi_o` most significant bit first while the same number of bits is collected from `miso_i`. The serial clock rate, its idle level and its sampling phase are all programmable.

When the exchange ends, a completion flag rises and, if enabled, so does the interrupt line. Software then releases the flag in two steps: an access to the status register followed by a read of the data register. Until that status access has happened, further data writes are dropped. An internal select is taken either from a software bit or from an external pin. If it goes low while the block is enabled, the master and enable bits are knocked off and a mode-fault bit is raised.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control and status registers read 0x00, `sck_o` rests low and `irq_o` is low.
- R2: A write to the data register (address 2) starts an exchange when enable (control bit 0) and master (control bit 1) are both 1 and no exchange is running. The byte is shifted out on `mosi_o` most significant bit first.
- R3: After the 8th bit, the completion flag (status bit 7) becomes 1. The bits gathered from `miso_i` (first bit received is the most significant) are latched, and a data-register read returns them.
- R4: `irq_o` is 1 exactly while the completion flag and interrupt enable (control bit 2) are both 1.
- R5: The completion flag clears only when a status-register access (address 1) made while the flag is set is followed by a data-register read. A data read with no prior status access leaves the flag set.
- R6: While the completion flag is set and no status access has yet been made, a data write is ignored: no serial clock activity follows and the flag stays set.
- R7: The rate field (status bits 2:0), with code n from 0 to 7, makes each serial clock half-period last 2^n system clocks.
- R8: Control bit 3 sets the idle level of `sck_o`. With control bit 4 at 0, the first bit is on `mosi_o` before the first clock edge and `miso_i` is sampled on odd-numbered edges. With it at 1, data changes on odd-numbered edges and is sampled on even-numbered edges. All four combinations exchange bytes correctly.
- R9: With status bit 3 at 1, the internal select equals status bit 4. With status bit 3 at 0, it follows the `ss_ni` pin.
- R10: While the internal select is low, the enable and master bits are forced to 0. If either was set when the select went low, mode fault (status bit 6) becomes 1. Mode fault is cleared by the same status-access-then-data-read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe; reads have side effects |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of `rd_i` |
| irq_o | output | 1 | Completion interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_ni | input | 1 | External select pin, low forces a mode fault |

## Verification
The hardest condition to reach is a data write that lands while the completion flag is still up and the status register has not yet been touched. Ordinary polling code reads status first and so never produces it. The bench waits on `irq_o` instead of polling, which leaves the flag pending without any status access. It then issues the write and counts serial clock toggles before any status read. The mode-fault path is reached both by pulling the pin low and by writing the software select bit to 0 while master mode is on.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned RATE_W = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control register bit positions
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_MST  = 1;
  localparam int unsigned C_IE   = 2;
  localparam int unsigned C_CPOL = 3;
  localparam int unsigned C_CPHA = 4;

  // status register bit positions
  localparam int unsigned S_SSM  = 3;
  localparam int unsigned S_SSI  = 4;
  localparam int unsigned S_MODF = 6;
  localparam int unsigned S_DONE = 7;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic ie;
    logic mst;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int unsigned RATE_W = 3,
  localparam int unsigned CNT_W = (1 << RATE_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(rate_i));
  end

  assign tick_o = busy_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!busy_i) cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && rate_i != '0) |=> !tick_o);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned EDGES  = 2 * DATA_W,
  localparam int unsigned EDGE_W = $clog2(EDGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              tick_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic              busy_q, sck_q, mosi_q, fin_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              lead, sample, last;

  assign lead   = !edge_q[0];
  assign sample = lead ^ cpha_i;
  assign last   = (edge_q == LAST_EDGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      fin_q  <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      fin_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        sck_q  <= cpol_i;
        if (cpha_i) begin
          tx_q <= tx_i;
        end else begin
          mosi_q <= tx_i[DATA_W-1];
          tx_q   <= {tx_i[DATA_W-2:0], 1'b0};
        end
      end else if (busy_q && tick_i) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + 1'b1;
        if (sample) begin
          rx_q <= {rx_q[DATA_W-2:0], miso_i};
        end else if (!last) begin
          mosi_q <= tx_q[DATA_W-1];
          tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end
        if (last) begin
          busy_q <= 1'b0;
          fin_q  <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = fin_q;
  assign sck_o  = busy_q ? sck_q : cpol_i;
  assign mosi_o = mosi_q;
  assign rx_o   = rx_q;

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> !busy_q);
  assert_end_after_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && last && !abort_i) |=> (!busy_q && fin_q));
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_master_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ss_ni,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic [DATA_W-1:0] rx_i,
  output ctrl_t             ctrl_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              start_o,
  output logic [DATA_W-1:0] tx_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [RATE_W-1:0] rate_q;
  logic              ssm_q, ssi_q, modf_q, done_q, arm_q;
  logic [DATA_W-1:0] rxbuf_q;
  logic              ss_int, stat_acc, data_rd, data_wr, ctrl_wr, stat_wr, clear;

  assign ss_int   = ssm_q ? ssi_q : ss_ni;
  assign stat_acc = (rd_i || wr_i) && (addr_i == ADDR_STAT);
  assign data_rd  = rd_i && (addr_i == ADDR_DATA);
  assign data_wr  = wr_i && (addr_i == ADDR_DATA);
  assign ctrl_wr  = wr_i && (addr_i == ADDR_CTRL);
  assign stat_wr  = wr_i && (addr_i == ADDR_STAT);
  assign clear    = data_rd && arm_q;

  assign start_o = data_wr && ctrl_q.en && ctrl_q.mst && !busy_i && !(done_q && !arm_q);
  assign tx_o    = wdata_i;
  assign irq_o   = done_q && ctrl_q.ie;
  assign ctrl_o  = ctrl_q;
  assign rate_o  = rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rate_q <= '0;
      ssm_q  <= 1'b0;
      ssi_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[C_CPHA:C_EN]);
      if (stat_wr) begin
        rate_q <= wdata_i[RATE_W-1:0];
        ssm_q  <= wdata_i[S_SSM];
        ssi_q  <= wdata_i[S_SSI];
      end
      if (!ss_int) begin
        ctrl_q.en  <= 1'b0;
        ctrl_q.mst <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      modf_q  <= 1'b0;
      arm_q   <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (fin_i) rxbuf_q <= rx_i;

      if (fin_i)      done_q <= 1'b1;
      else if (clear) done_q <= 1'b0;

      if (!ss_int && (ctrl_q.en || ctrl_q.mst)) modf_q <= 1'b1;
      else if (clear)                           modf_q <= 1'b0;

      if (clear)                              arm_q <= 1'b0;
      else if (stat_acc && (done_q || modf_q)) arm_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_CTRL: rdata_o[C_CPHA:C_EN] = ctrl_q;
        ADDR_STAT: begin
          rdata_o[RATE_W-1:0] = rate_q;
          rdata_o[S_SSM]      = ssm_q;
          rdata_o[S_SSI]      = ssi_q;
          rdata_o[S_MODF]     = modf_q;
          rdata_o[S_DONE]     = done_q;
        end
        ADDR_DATA: rdata_o = rxbuf_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assert_flag_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> done_q);
  assert_flag_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_q) |-> $past(data_rd && arm_q));
  assert_blocked_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && done_q && !arm_q && !busy_i) |=> !busy_i);
  assert_mode_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_int |=> (!ctrl_q.en && !ctrl_q.mst));
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_master_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        wr_i,
  input  logic        rd_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  input  logic        ss_ni
);
  ctrl_t             ctrl;
  logic [RATE_W-1:0] rate;
  logic              start, busy, fin, tick;
  logic [DATA_W-1:0] tx, rx;

  spi_reg_file #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .ss_ni,
    .busy_i(busy), .fin_i(fin), .rx_i(rx), .ctrl_o(ctrl), .rate_o(rate),
    .start_o(start), .tx_o(tx), .irq_o
  );

  spi_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk_i, .rst_ni, .busy_i(busy), .rate_i(rate), .tick_o(tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i, .rst_ni, .start_i(start), .abort_i(!(ctrl.en && ctrl.mst)),
    .tick_i(tick), .cpol_i(ctrl.cpol), .cpha_i(ctrl.cpha), .tx_i(tx),
    .miso_i, .busy_o(busy), .fin_o(fin), .sck_o, .mosi_o, .rx_o(rx)
  );
endmodule

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, sck_o, mosi_o, miso_i;
  logic       ss_ni = 1'b1;

  int errors = 0, checks = 0;

  logic       mon_cpol = 1'b0, mon_cpha = 1'b0;
  int         idx = 0, toggles = 0;
  logic [7:0] cap = '0, slave = '0;
  longint     t_prev = 0, half_ns = 0;

  always #4 clk_i = ~clk_i;

  spi_byte_master u_spi_byte_master (.*);

  always_comb miso_i = (idx < 8) ? slave[7 - idx] : 1'b0;

  always @(sck_o) begin
    toggles++;
    half_ns = $time - t_prev;
    t_prev  = $time;
    if (((sck_o != mon_cpol) ? 1'b1 : 1'b0) == !mon_cpha) begin
      cap = {cap[6:0], mosi_o};
      idx++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq_o && n < 5000) begin @(negedge clk_i); n++; end
    check(req, irq_o, 1'b1);
  endtask

  task automatic setup(input logic cpol, input logic cpha, input logic [2:0] rate);
    bus_wr(2'd1, {3'b000, 1'b1, 1'b1, rate});
    mon_cpol = cpol; mon_cpha = cpha;
    bus_wr(2'd0, {3'b000, cpha, cpol, 1'b1, 1'b1, 1'b1});
    idx = 0; cap = '0;
  endtask

  task automatic test_reset();
    logic [7:0] v;
    bus_rd(2'd0, v); check("R1 ctrl", v, 8'h00);
    bus_rd(2'd1, v); check("R1 status", v, 8'h00);
    check("R1 sck", sck_o, 1'b0);
    check("R1 irq", irq_o, 1'b0);
  endtask

  task automatic test_xfer(input logic cpol, input logic cpha, input logic [2:0] rate,
                           input logic [7:0] tx, input logic [7:0] sl);
    logic [7:0] v;
    setup(cpol, cpha, rate);
    slave = sl;
    bus_wr(2'd2, tx);
    wait_irq("R4 irq on done");
    check("R2 mosi msb first", cap, tx);
    check("R8 sck idle level", sck_o, cpol);
    check("R7 half period", half_ns, 64'd8 << rate);
    bus_rd(2'd1, v); check("R3 done flag", v[7], 1'b1);
    bus_rd(2'd2, v); check("R3 rx byte", v, sl);
    bus_rd(2'd1, v); check("R5 flag cleared", v[7], 1'b0);
    check("R4 irq low", irq_o, 1'b0);
  endtask

  task automatic test_blocked();
    logic [7:0] v;
    int t0;
    setup(1'b0, 1'b0, 3'd0);
    slave = 8'h3C;
    bus_wr(2'd2, 8'h81);
    wait_irq("R4 irq");
    t0 = toggles;
    bus_wr(2'd2, 8'hFF);
    repeat (40) @(negedge clk_i);
    check("R6 write ignored", toggles - t0, 0);
    bus_rd(2'd2, v); check("R6 rx unchanged", v, 8'h3C);
    bus_rd(2'd1, v); check("R5 data read alone keeps flag", v[7], 1'b1);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check("R5 sequence clears", v[7], 1'b0);
  endtask

  task automatic test_select();
    logic [7:0] v;
    bus_wr(2'd1, 8'h00);          // pin-driven select
    bus_wr(2'd0, 8'h03);
    bus_rd(2'd0, v); check("R9 pin high keeps master", v[1:0], 2'b11);
    @(negedge clk_i); ss_ni = 1'b0;
    @(negedge clk_i); ss_ni = 1'b1;
    bus_rd(2'd0, v); check("R10 pin low drops bits", v[1:0], 2'b00);
    bus_rd(2'd1, v); check("R10 mode fault", v[6], 1'b1);
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check("R10 fault cleared", v[6], 1'b0);
    bus_wr(2'd1, 8'h18);          // software select, high
    @(negedge clk_i); ss_ni = 1'b0;
    bus_wr(2'd0, 8'h03);
    bus_rd(2'd0, v); check("R9 software select ignores pin", v[1:0], 2'b11);
    bus_wr(2'd1, 8'h08);          // software select, low
    bus_rd(2'd0, v); check("R9 software select low drops", v[1:0], 2'b00);
    bus_rd(2'd1, v); check("R10 fault by bit", v[6], 1'b1);
    @(negedge clk_i); ss_ni = 1'b1;
    bus_rd(2'd2, v);
    bus_rd(2'd1, v); check("R10 fault cleared again", v[6], 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        test_reset();
        test_xfer(1'b0, 1'b0, 3'd0, 8'hA5, 8'h5A);
        test_xfer(1'b0, 1'b1, 3'd1, 8'h3C, 8'hC1);
        test_xfer(1'b1, 1'b0, 3'd2, 8'h81, 8'h7E);
        test_xfer(1'b1, 1'b1, 3'd7, 8'h6D, 8'h92);
        test_blocked();
        test_select();
      end
      begin
        repeat (150000) @(posedge clk_i);
        check("watchdog", 1'b1, 1'b0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule